// File: doc/BRIEF.md
# Raster Line and Frame Timing Sequencer

This block keeps the dot and line timing for a fixed-size raster display. A dot counter runs across each 456-dot line and a line counter runs across a 154-line frame; both advance only on cycles where the dot-clock enable is high. From the two counters the block derives the current display mode, reports the line number, and compares that line against a compare register that the CPU can write.

Two single-cycle interrupt requests leave the block. The first marks entry into vertical blank. The second is a status request whose sources the CPU selects with a four-bit enable. The block also sits between the CPU and the video and sprite-attribute memories, and it blocks access in the modes where the display owns those memories.

Top module: `raster_timing_seq`

## Requirements
- R1: The dot counter advances by one on each cycle with `dot_en` high and holds when it is low. After dot DOTS_PER_LINE-1 (455) it returns to 0 and the line counter increments; `line` shows the line counter.
- R2: After the last dot of line TOTAL_LINES-1 (153), `line` returns to 0.
- R3: On a visible line (below VIS_LINES, 144), `mode` is 2 for dots 0 to SCAN_DOTS-1 (0..79), 3 for the next XFER_DOTS dots (80..251), and 0 for the rest of the line (252..455).
- R4: On lines VIS_LINES to TOTAL_LINES-1 (144..153), `mode` is 1 for every dot.
- R5: With `cpu_sel` = 0 (video memory), in mode 3 `cpu_rdata` is 8'hFF and `vram_we` stays low even when `cpu_wr` is high. In any other mode `cpu_rdata` equals `vram_rdata` and `vram_we` follows `cpu_wr`.
- R6: With `cpu_sel` = 1 (sprite attribute memory), in modes 2 and 3 `cpu_rdata` is 8'hFF and `oam_we` stays low. In modes 0 and 1 `cpu_rdata` equals `oam_rdata` and `oam_we` follows `cpu_wr`.
- R7: A write with `cmp_we` high loads `cmp_wdata` into the compare register at the clock edge. `line_match` is high exactly while `line` equals that register.
- R8: `vblank_irq` is high for a single cycle, the first cycle in which `mode` is 1 (line VIS_LINES, dot 0).
- R9: When `stat_en[3]` is set, `stat_irq` pulses for one cycle in the first cycle that `line_match` is high after a cycle in which it was low.
- R10: `stat_irq` also pulses for one cycle in the first cycle of mode 0, 1 or 2 when `stat_en[0]`, `stat_en[1]` or `stat_en[2]` is set, respectively. Entry into mode 3 never raises it, and with `stat_en` = 0 it never pulses.
- R11: While `rst` is high, the counters clear to line 0 and dot 0, `mode` is 2, the compare register is 0, and both interrupt requests are low. No interrupt request pulses in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dot_en | input | 1 | Advances the timing by one dot |
| cmp_we | input | 1 | Write strobe for the line-compare register |
| cmp_wdata | input | LINE_W | New line-compare value |
| stat_en | input | 4 | Status request sources: bit0 mode 0 entry, bit1 mode 1 entry, bit2 mode 2 entry, bit3 line match |
| cpu_sel | input | 1 | CPU target: 0 video memory, 1 sprite attribute memory |
| cpu_wr | input | 1 | CPU write request |
| vram_rdata | input | 8 | Read data from video memory |
| oam_rdata | input | 8 | Read data from sprite attribute memory |
| mode | output | 2 | Current display mode (0 hblank, 1 vblank, 2 sprite scan, 3 transfer) |
| line | output | LINE_W | Current line number |
| line_match | output | 1 | Line equals the compare register |
| vblank_irq | output | 1 | Vertical blank entry pulse |
| stat_irq | output | 1 | Status interrupt pulse |
| cpu_rdata | output | 8 | Gated read data returned to the CPU |
| vram_we | output | 1 | Gated video memory write enable |
| oam_we | output | 1 | Gated sprite attribute memory write enable |

## Verification
The bench builds the block with 20 dots per line, a 4-dot scan, a 6-dot transfer, 5 visible lines and 8 lines per frame, so a full frame is 160 dots. At that size, several frame wraps, every mode boundary and every vertical blank entry fall within a few hundred cycles. Because the timing is shrunk, the runs also fit a stalled dot enable, a compare write that matches the current line in the middle of a line, and a section with all status sources off. A reference model in the bench follows each edge and predicts every output, including the memory gating on alternating targets.

// File: rtl/rts_pkg.sv
package rts_pkg;

    typedef enum logic [1:0] {
        MODE_HBLANK = 2'd0,
        MODE_VBLANK = 2'd1,
        MODE_SCAN   = 2'd2,
        MODE_XFER   = 2'd3
    } lcd_mode_e;

    typedef struct packed {
        logic vram_blk;
        logic oam_blk;
    } access_t;

    localparam logic [7:0] BLOCKED_READ = 8'hFF;

    function automatic access_t access_of(lcd_mode_e m);
        access_t a;
        a.vram_blk = (m == MODE_XFER);
        a.oam_blk  = (m == MODE_XFER) || (m == MODE_SCAN);
        return a;
    endfunction

endpackage

// File: rtl/rts_counter.sv
module rts_counter #(
    parameter int DOTS_PER_LINE = 456,
    parameter int TOTAL_LINES   = 154,
    parameter int DOT_W         = $clog2(DOTS_PER_LINE),
    parameter int LINE_W        = $clog2(TOTAL_LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dot_en,
    output logic [DOT_W-1:0]  dot,
    output logic [LINE_W-1:0] line
);
    localparam logic [DOT_W-1:0]  DOT_LAST  = DOT_W'(DOTS_PER_LINE - 1);
    localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(TOTAL_LINES - 1);

    logic [DOT_W-1:0]  dot_q;
    logic [LINE_W-1:0] line_q;
    logic              end_of_line;
    logic              end_of_frame;

    assign end_of_line  = (dot_q == DOT_LAST);
    assign end_of_frame = end_of_line && (line_q == LINE_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            dot_q  <= '0;
            line_q <= '0;
        end else if (dot_en) begin
            if (end_of_line) begin
                dot_q  <= '0;
                line_q <= end_of_frame ? '0 : line_q + 1'b1;
            end else begin
                dot_q <= dot_q + 1'b1;
            end
        end
    end

    assign dot  = dot_q;
    assign line = line_q;

    AST_DOT_BOUND: assert property (@(posedge clk) disable iff (rst)
        dot_q <= DOT_LAST) else $error("dot beyond line end"); // R1
    AST_LINE_BOUND: assert property (@(posedge clk) disable iff (rst)
        line_q <= LINE_LAST) else $error("line beyond frame end"); // R2
    AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (rst)
        !dot_en |=> ($stable(dot_q) && $stable(line_q))) else $error("count moved without enable"); // R1
    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
        (dot_en && end_of_frame) |=> (line_q == '0 && dot_q == '0)) else $error("frame wrap missed"); // R2

endmodule

// File: rtl/rts_mode_dec.sv
module rts_mode_dec
    import rts_pkg::*;
#(
    parameter int SCAN_DOTS = 80,
    parameter int XFER_DOTS = 172,
    parameter int VIS_LINES = 144,
    parameter int DOT_W     = 9,
    parameter int LINE_W    = 8
) (
    input  logic [DOT_W-1:0]  dot,
    input  logic [LINE_W-1:0] line,
    output lcd_mode_e         mode
);
    localparam logic [DOT_W-1:0]  SCAN_END = DOT_W'(SCAN_DOTS);
    localparam logic [DOT_W-1:0]  XFER_END = DOT_W'(SCAN_DOTS + XFER_DOTS);
    localparam logic [LINE_W-1:0] VBL_LINE = LINE_W'(VIS_LINES);

    always_comb begin
        if (line >= VBL_LINE)
            mode = MODE_VBLANK;
        else if (dot < SCAN_END)
            mode = MODE_SCAN;
        else if (dot < XFER_END)
            mode = MODE_XFER;
        else
            mode = MODE_HBLANK;
    end

    always_comb begin
        AST_VIS_NOT_VBL: assert (!(line < VBL_LINE && mode == MODE_VBLANK) || $isunknown(line)); // R3
    end

endmodule

// File: rtl/rts_irq.sv
module rts_irq
    import rts_pkg::*;
#(
    parameter int VIS_LINES = 144,
    parameter int LINE_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmp_we,
    input  logic [LINE_W-1:0] cmp_wdata,
    input  logic [3:0]        stat_en,
    input  logic [LINE_W-1:0] line,
    input  lcd_mode_e         mode,
    output logic              line_match,
    output logic              vblank_irq,
    output logic              stat_irq
);
    localparam int N_MODE_SRC = 3;

    logic [LINE_W-1:0]     cmp_q;
    lcd_mode_e             mode_q;
    logic                  match_q;
    logic [N_MODE_SRC-1:0] entry;
    logic                  match_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q   <= '0;
            mode_q  <= MODE_SCAN;
            match_q <= 1'b1;
        end else begin
            if (cmp_we)
                cmp_q <= cmp_wdata;
            mode_q  <= mode;
            match_q <= line_match;
        end
    end

    assign line_match = (line == cmp_q);
    assign match_rise = line_match && !match_q;

    generate
        for (genvar i = 0; i < N_MODE_SRC; i++) begin : g_entry
            assign entry[i] = stat_en[i]
                           && (mode == lcd_mode_e'(2'(i)))
                           && (mode_q != lcd_mode_e'(2'(i)));
        end
    endgenerate

    assign vblank_irq = (mode == MODE_VBLANK) && (mode_q != MODE_VBLANK);
    assign stat_irq   = (|entry) || (stat_en[3] && match_rise);

    AST_VBL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        vblank_irq |=> !vblank_irq) else $error("vblank pulse too long"); // R8
    AST_VBL_AT_LINE: assert property (@(posedge clk) disable iff (rst)
        vblank_irq |-> (line == LINE_W'(VIS_LINES))) else $error("vblank pulse off line"); // R8
    AST_STAT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (stat_en == 4'b0000) |-> !stat_irq) else $error("status pulse with no source"); // R10
    AST_MATCH_PULSE: assert property (@(posedge clk) disable iff (rst)
        (stat_en[3] && $rose(line_match)) |-> stat_irq) else $error("match pulse missed"); // R9

endmodule

// File: rtl/rts_gate.sv
module rts_gate
    import rts_pkg::*;
(
    input  lcd_mode_e  mode,
    input  logic       cpu_sel,
    input  logic       cpu_wr,
    input  logic [7:0] vram_rdata,
    input  logic [7:0] oam_rdata,
    output logic [7:0] cpu_rdata,
    output logic       vram_we,
    output logic       oam_we
);
    access_t acc;

    assign acc = access_of(mode);

    always_comb begin
        if (cpu_sel)
            cpu_rdata = acc.oam_blk ? BLOCKED_READ : oam_rdata;
        else
            cpu_rdata = acc.vram_blk ? BLOCKED_READ : vram_rdata;
    end

    assign vram_we = cpu_wr && !cpu_sel && !acc.vram_blk;
    assign oam_we  = cpu_wr &&  cpu_sel && !acc.oam_blk;

    always_comb begin
        AST_VRAM_NO_WE: assert (!(mode == MODE_XFER && vram_we)); // R5
        AST_OAM_NO_WE:  assert (!((mode == MODE_XFER || mode == MODE_SCAN) && oam_we)); // R6
    end

endmodule

// File: rtl/raster_timing_seq.sv
module raster_timing_seq
    import rts_pkg::*;
#(
    parameter int DOTS_PER_LINE = 456,
    parameter int SCAN_DOTS     = 80,
    parameter int XFER_DOTS     = 172,
    parameter int VIS_LINES     = 144,
    parameter int TOTAL_LINES   = 154,
    parameter int LINE_W        = $clog2(TOTAL_LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dot_en,
    input  logic              cmp_we,
    input  logic [LINE_W-1:0] cmp_wdata,
    input  logic [3:0]        stat_en,
    input  logic              cpu_sel,
    input  logic              cpu_wr,
    input  logic [7:0]        vram_rdata,
    input  logic [7:0]        oam_rdata,
    output logic [1:0]        mode,
    output logic [LINE_W-1:0] line,
    output logic              line_match,
    output logic              vblank_irq,
    output logic              stat_irq,
    output logic [7:0]        cpu_rdata,
    output logic              vram_we,
    output logic              oam_we
);
    localparam int DOT_W = $clog2(DOTS_PER_LINE);

    logic [DOT_W-1:0]  dot_w;
    logic [LINE_W-1:0] line_w;
    lcd_mode_e         mode_w;

    rts_counter #(
        .DOTS_PER_LINE(DOTS_PER_LINE),
        .TOTAL_LINES  (TOTAL_LINES),
        .DOT_W        (DOT_W),
        .LINE_W       (LINE_W)
    ) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .dot_en(dot_en),
        .dot   (dot_w),
        .line  (line_w)
    );

    rts_mode_dec #(
        .SCAN_DOTS(SCAN_DOTS),
        .XFER_DOTS(XFER_DOTS),
        .VIS_LINES(VIS_LINES),
        .DOT_W    (DOT_W),
        .LINE_W   (LINE_W)
    ) u_dec (
        .dot (dot_w),
        .line(line_w),
        .mode(mode_w)
    );

    rts_irq #(
        .VIS_LINES(VIS_LINES),
        .LINE_W   (LINE_W)
    ) u_irq (
        .clk       (clk),
        .rst       (rst),
        .cmp_we    (cmp_we),
        .cmp_wdata (cmp_wdata),
        .stat_en   (stat_en),
        .line      (line_w),
        .mode      (mode_w),
        .line_match(line_match),
        .vblank_irq(vblank_irq),
        .stat_irq  (stat_irq)
    );

    rts_gate u_gate (
        .mode      (mode_w),
        .cpu_sel   (cpu_sel),
        .cpu_wr    (cpu_wr),
        .vram_rdata(vram_rdata),
        .oam_rdata (oam_rdata),
        .cpu_rdata (cpu_rdata),
        .vram_we   (vram_we),
        .oam_we    (oam_we)
    );

    assign mode = mode_w;
    assign line = line_w;

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (line == '0 && mode == 2'd2 && !vblank_irq && !stat_irq)) else $error("bad reset state"); // R11
    AST_VBL_MODE: assert property (@(posedge clk) disable iff (rst)
        (line >= LINE_W'(VIS_LINES)) |-> (mode == 2'd1)) else $error("blank lines not in mode 1"); // R4

endmodule

// File: tb/sim_raster_timing_seq.sv
module sim_raster_timing_seq;
    localparam int DPL = 20;
    localparam int SCN = 4;
    localparam int XFR = 6;
    localparam int VIS = 5;
    localparam int TOT = 8;
    localparam int LW  = $clog2(TOT);
    localparam logic [7:0] VDATA = 8'h5A;
    localparam logic [7:0] ODATA = 8'hC3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          dot_en = 1'b0;
    logic          cmp_we = 1'b0;
    logic [LW-1:0] cmp_wdata = '0;
    logic [3:0]    stat_en = 4'b0000;
    logic          cpu_sel = 1'b0;
    logic          cpu_wr = 1'b0;
    logic [1:0]    mode;
    logic [LW-1:0] line;
    logic          line_match, vblank_irq, stat_irq, vram_we, oam_we;
    logic [7:0]    cpu_rdata;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    raster_timing_seq #(
        .DOTS_PER_LINE(DPL), .SCAN_DOTS(SCN), .XFER_DOTS(XFR),
        .VIS_LINES(VIS), .TOTAL_LINES(TOT)
    ) u0 (
        .clk(clk), .rst(rst), .dot_en(dot_en), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
        .stat_en(stat_en), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
        .vram_rdata(VDATA), .oam_rdata(ODATA),
        .mode(mode), .line(line), .line_match(line_match), .vblank_irq(vblank_irq),
        .stat_irq(stat_irq), .cpu_rdata(cpu_rdata), .vram_we(vram_we), .oam_we(oam_we)
    );

    typedef struct {
        int  mode;
        int  line;
        bit  match;
        bit  vbl;
        bit  stat;
        bit  stat_from_match;
        int  rdata;
        bit  vwe;
        bit  owe;
        bit  sel;
        bit  wrap;
    } exp_t;

    exp_t q[$];

    int m_dot = 0, m_line = 0, m_cmp = 0, m_prev_mode = 2;
    bit m_prev_match = 1'b1;

    task automatic check(string req, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, got, exp, $time);
        end
    endtask

    function automatic int mode_of(int d, int l);
        if (l >= VIS) return 1;
        if (d < SCN) return 2;
        if (d < SCN + XFR) return 3;
        return 0;
    endfunction

    // driver: applies one cycle of stimulus and predicts the outputs after the edge
    task automatic step(bit en, bit sel, bit wr, bit cwe, int cval, logic [3:0] sen);
        exp_t e;
        int nm;
        bit nmatch, vblk, oblk, mrise, ent;
        @(negedge clk);
        rst = 1'b0;
        dot_en = en; cpu_sel = sel; cpu_wr = wr; cmp_we = cwe;
        cmp_wdata = LW'(cval); stat_en = sen;
        e.wrap = 1'b0;
        if (cwe) m_cmp = cval;
        if (en) begin
            if (m_dot == DPL - 1) begin
                m_dot = 0;
                if (m_line == TOT - 1) begin
                    m_line = 0;
                    e.wrap = 1'b1;
                end else m_line++;
            end else m_dot++;
        end
        nm = mode_of(m_dot, m_line);
        nmatch = (m_line == m_cmp);
        mrise = nmatch && !m_prev_match;
        ent = (nm != m_prev_mode) && (nm != 3) && sen[nm];
        e.mode = nm;
        e.line = m_line;
        e.match = nmatch;
        e.vbl = (nm == 1) && (m_prev_mode != 1);
        e.stat_from_match = sen[3] && mrise;
        e.stat = ent || e.stat_from_match;
        vblk = (nm == 3);
        oblk = (nm == 3) || (nm == 2);
        e.sel = sel;
        if (sel) e.rdata = oblk ? 255 : int'(ODATA);
        else     e.rdata = vblk ? 255 : int'(VDATA);
        e.vwe = wr && !sel && !vblk;
        e.owe = wr && sel && !oblk;
        q.push_back(e);
        m_prev_mode = nm;
        m_prev_match = nmatch;
    endtask

    // monitor: pops expectations and compares them well after the edge
    always @(posedge clk) begin
        #5;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check((e.line >= VIS) ? "R4 mode" : "R3 mode", int'(mode), e.mode);
            check("R1 line", int'(line), e.line);
            if (e.wrap) check("R2 line wrap", int'(line), 0);
            check("R7 line_match", int'(line_match), int'(e.match));
            check("R8 vblank_irq", int'(vblank_irq), int'(e.vbl));
            check(e.stat_from_match ? "R9 stat_irq" : "R10 stat_irq", int'(stat_irq), int'(e.stat));
            check(e.sel ? "R6 cpu_rdata" : "R5 cpu_rdata", int'(cpu_rdata), e.rdata);
            check("R5 vram_we", int'(vram_we), int'(e.vwe));
            check("R6 oam_we", int'(oam_we), int'(e.owe));
        end
    end

    initial begin
        #(20 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        // R11: reset values while rst is held
        check("R11 line", int'(line), 0);
        check("R11 mode", int'(mode), 2);
        check("R11 vblank_irq", int'(vblank_irq), 0);
        check("R11 stat_irq", int'(stat_irq), 0);
        check("R11 line_match", int'(line_match), 1);

        // full frame plus wrap, all status sources on, compare at line 3
        for (int i = 0; i < 2 * DPL * TOT + 10; i++)
            step(1'b1, i[0], 1'b1, i == 0, 3, 4'b1111);

        // stalled dot enable, match source only, compare rewritten mid-line
        for (int i = 0; i < 90; i++) begin
            int cv;
            cv = (i == 45) ? m_line : m_cmp;
            step(i % 3 == 0, i[0], i[1], i == 45, cv, 4'b1000);
        end

        // all status sources off across a frame
        for (int i = 0; i < DPL * TOT + 20; i++)
            step(1'b1, i[1], 1'b1, 1'b0, 0, 4'b0000);

        // mode-entry sources one at a time
        for (int i = 0; i < DPL * TOT; i++)
            step(1'b1, i[0], 1'b0, 1'b0, 0, 4'(1 << ((i / 40) % 3)));

        repeat (3) @(posedge clk);
        #7;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule